// File: doc/BRIEF.md
# Sound and MIDI Peripheral Host Register Front End

This block is the host-facing register file of a sound and MIDI peripheral. The host first loads an 8-bit address latch. It then reads or writes data through one of two channel ports that share that latch. Channel 0 reaches every register: the base and timer bank, the first PCM bank and the two MIDI registers. Channel 1 reaches only a second PCM bank, which sits at the same addresses as the first one. Every register byte is exported as a flat image, so that the timer, MIDI and playback blocks can use the settings directly.

The block also keeps an 8-bit event status register. The neighbouring timer and MIDI blocks set its bits with one-cycle pulses. A host status read returns the value and clears it. An active-high, level-sensitive interrupt line is raised when any status bit is set whose source is enabled. A source is enabled when its mask bit is cleared.

Top module: `snd_host_regs`

## Requirements
- R1: After synchronous reset, every register reads 0x00 except these: address 0 holds 0x01, address 9 and PCM bank 1 entry 0 hold 0x80, and address 13 holds 0x0A. The status register is 0, `irq` is 0 and both read-data outputs are 0.
- R2: A cycle with `addr_wr` high loads `bus_din` into the address latch. A data access in that same cycle still uses the previous latch value.
- R3: A channel 0 write (`bus_chan`=0) to latched address 0..14 replaces that register byte. Writes to addresses of 15 and above change nothing. In `reg_image`, byte k (bits 8k+7:8k) holds channel 0 address k for k = 0..14, and PCM bank 1 entries 0..3 for k = 15..18.
- R4: A channel 1 write reaches only addresses 9..12, which update PCM bank 1 entry (address − 9). Channel 1 writes to any other address leave the whole image unchanged.
- R5: `bus_dout` loads the addressed byte on the clock edge that samples `bus_rd`, and holds its value otherwise. Unmapped reads return 0xFF: addresses of 15 and above on channel 0, and anything outside 9..12 on channel 1. A read and a write in the same cycle return the old byte.
- R6: A status read (`stat_rd`) loads the pre-edge status value into `stat_dout` and clears every status bit on that edge. `stat_dout` holds its value otherwise.
- R7: Each bit of `flag_set` sets the matching status bit, and that bit stays set until a status read. If a pulse arrives in the same cycle as a status read, it is left out of the returned value and remains set afterwards.
- R8: The status bit positions are: 0 and 1 for FIFO events, 2 for MIDI receive request, 3 for MIDI transmit request, 4/5/6 for timer 0/1/2 expiry, and 7 for overflow. Timer bits 4..6 are enabled when bits 4..6 of the timer control register (address 8) are 0. Bit 3 is enabled when bits 3 and 2 of MIDI control (address 13) are both 0. Bits 0, 1, 2 and 7 never raise `irq`.
- R9: `irq` is high exactly when an enabled status bit is set. It follows register and status changes in the same cycle they take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_wr | input | 1 | Load the address latch from `bus_din` |
| bus_wr | input | 1 | Data write through the selected channel |
| bus_rd | input | 1 | Data read through the selected channel |
| bus_chan | input | 1 | Channel select: 0 = full map, 1 = PCM bank 1 only |
| bus_din | input | 8 | Address or write data |
| bus_dout | output | 8 | Registered read data |
| stat_rd | input | 1 | Status read-and-clear strobe |
| stat_dout | output | 8 | Registered status value from the last status read |
| flag_set | input | 8 | One-cycle flag-set pulses from the timer and MIDI blocks |
| irq | output | 1 | Active-high, level interrupt request |
| reg_image | output | 152 | All 19 register bytes, byte k at bits 8k+7:8k |

## Verification
Register writes, address latch loads and status flag updates take effect on the edge that samples the strobe. They are therefore visible in `reg_image` and in the next status read one cycle after the stimulus. `bus_dout` and `stat_dout` are also due on that same edge. `irq` settles in the same cycle as the state it depends on. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It compares every output at the following falling edge, which is exactly one register stage after each stimulus. Directed cases cover the same-cycle read/pulse collision, channel 1 rejection and each enable condition.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int DW        = 8;
  localparam int AW        = 8;
  localparam int NADDR     = 15;
  localparam int PCM_BASE  = 9;
  localparam int PCM_LEN   = 4;
  localparam int NSLOT     = NADDR + PCM_LEN;
  localparam int SW        = $clog2(NSLOT);
  localparam int TCTL_ADDR = 8;
  localparam int MCTL_ADDR = 13;

  // power-on contents of each storage slot
  function automatic logic [DW-1:0] slot_init(input int slot);
    if (slot == 0) return 8'h01;
    if (slot == PCM_BASE || slot == NADDR) return 8'h80;
    if (slot == MCTL_ADDR) return 8'h0A;
    return '0;
  endfunction
endpackage

// File: rtl/shr_decode.sv
module shr_decode
  import shr_pkg::*;
#(
  parameter int A_W   = AW,
  parameter int S_W   = SW,
  parameter int N_ADR = NADDR,
  parameter int P_LO  = PCM_BASE,
  parameter int P_N   = PCM_LEN
) (
  input  logic [A_W-1:0] addr,
  input  logic           chan,
  output logic           hit,
  output logic [S_W-1:0] slot
);
  localparam int P_HI = P_LO + P_N;

  always_comb begin
    hit  = 1'b0;
    slot = '0;
    if (!chan) begin
      hit  = (int'(addr) < N_ADR);
      slot = S_W'(addr);
    end else begin
      hit  = (int'(addr) >= P_LO) && (int'(addr) < P_HI);
      slot = S_W'(int'(addr) - P_LO + N_ADR);
    end
  end
endmodule

// File: rtl/shr_regfile.sv
module shr_regfile
  import shr_pkg::*;
#(
  parameter int D_W = DW,
  parameter int S_W = SW,
  parameter int N_S = NSLOT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             re,
  input  logic             hit,
  input  logic [S_W-1:0]   slot,
  input  logic [D_W-1:0]   wdata,
  output logic [D_W-1:0]   rdata,
  output logic [N_S*D_W-1:0] image
);
  logic [D_W-1:0] q [N_S];

  for (genvar k = 0; k < N_S; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        q[k] <= slot_init(k);
      else if (we && hit && slot == S_W'(k))
        q[k] <= wdata;
    end
    assign image[k*D_W +: D_W] = q[k];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (re)
      rdata <= hit ? q[slot] : '1;
  end
endmodule

// File: rtl/shr_status.sv
module shr_status
  import shr_pkg::*;
#(
  parameter int D_W = DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd,
  input  logic [D_W-1:0] set,
  input  logic [D_W-1:0] tctl,
  input  logic [D_W-1:0] mctl,
  output logic [D_W-1:0] sdata,
  output logic [D_W-1:0] stat_q,
  output logic           irq
);
  logic [D_W-1:0] en;

  always_comb begin
    en      = '0;
    en[6:4] = ~tctl[6:4];
    en[3]   = ~(mctl[3] | mctl[2]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      sdata  <= '0;
    end else begin
      stat_q <= (rd ? '0 : stat_q) | set;
      if (rd) sdata <= stat_q;
    end
  end

  assign irq = |(stat_q & en);
endmodule

// File: rtl/snd_host_regs.sv
module snd_host_regs
  import shr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 addr_wr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic                 bus_chan,
  input  logic [DW-1:0]        bus_din,
  output logic [DW-1:0]        bus_dout,
  input  logic                 stat_rd,
  output logic [DW-1:0]        stat_dout,
  input  logic [DW-1:0]        flag_set,
  output logic                 irq,
  output logic [NSLOT*DW-1:0]  reg_image
);
  logic [AW-1:0] addr_q;
  logic          hit;
  logic [SW-1:0] slot;
  logic [DW-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst)          addr_q <= '0;
    else if (addr_wr) addr_q <= AW'(bus_din);
  end

  shr_decode u_dec (
    .addr (addr_q),
    .chan (bus_chan),
    .hit  (hit),
    .slot (slot)
  );

  shr_regfile u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (bus_wr),
    .re    (bus_rd),
    .hit   (hit),
    .slot  (slot),
    .wdata (bus_din),
    .rdata (bus_dout),
    .image (reg_image)
  );

  shr_status u_st (
    .clk    (clk),
    .rst    (rst),
    .rd     (stat_rd),
    .set    (flag_set),
    .tctl   (reg_image[TCTL_ADDR*DW +: DW]),
    .mctl   (reg_image[MCTL_ADDR*DW +: DW]),
    .sdata  (stat_dout),
    .stat_q (stat_q),
    .irq    (irq)
  );
endmodule

// File: rtl/shr_chk.sv
module shr_chk
  import shr_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                addr_wr,
  input logic                bus_wr,
  input logic                bus_chan,
  input logic [AW-1:0]       addr_q,
  input logic                stat_rd,
  input logic [DW-1:0]       flag_set,
  input logic [DW-1:0]       stat_q,
  input logic [DW-1:0]       stat_dout,
  input logic                irq,
  input logic [NSLOT*DW-1:0] reg_image
);
  // R1: reset leaves status empty and interrupt low
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (stat_q == '0 && !irq));

  // R6: the value returned by a status read is the status before the edge
  a_r6_read_value: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> stat_dout == $past(stat_q));

  // R7: after a read only the same-cycle pulses remain
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> stat_q == $past(flag_set));

  // R7: without a read no status bit is lost
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> (stat_q & $past(stat_q)) == $past(stat_q));

  // R4: channel 1 writes outside the PCM window change nothing
  a_r4_ch1_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_chan && (int'(addr_q) < PCM_BASE || int'(addr_q) >= PCM_BASE + PCM_LEN))
      |=> $stable(reg_image));

  // R8: status bits with no enable path never raise the interrupt
  a_r8_no_irq_idle: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & 8'h78) == '0) |-> !irq);
endmodule

bind snd_host_regs shr_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .addr_wr   (addr_wr),
  .bus_wr    (bus_wr),
  .bus_chan  (bus_chan),
  .addr_q    (addr_q),
  .stat_rd   (stat_rd),
  .flag_set  (flag_set),
  .stat_q    (stat_q),
  .stat_dout (stat_dout),
  .irq       (irq),
  .reg_image (reg_image)
);

// File: tb/snd_host_regs_test.sv
module snd_host_regs_test;
  logic         clk = 0;
  logic         rst = 1;
  logic         addr_wr = 0, bus_wr = 0, bus_rd = 0, bus_chan = 0, stat_rd = 0;
  logic [7:0]   bus_din = 0, flag_set = 0;
  logic [7:0]   bus_dout, stat_dout;
  logic         irq;
  logic [151:0] reg_image;

  int n_cmp = 0, n_bad = 0;

  // behavioural reference model
  logic [7:0] m_reg [19];
  logic [7:0] m_addr, m_stat, m_dout, m_sdout;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;  // 125 MHz

  snd_host_regs uut (.*);

  function automatic int map(input logic c, input logic [7:0] a);
    if (!c) return (a < 15) ? int'(a) : -1;
    return (a >= 9 && a < 13) ? int'(a) + 6 : -1;
  endfunction

  function automatic logic m_irq();
    logic [7:0] en;
    en = 8'h00;
    en[6:4] = ~m_reg[8][6:4];
    en[3]   = ~(m_reg[13][3] | m_reg[13][2]);
    return |(m_stat & en);
  endfunction

  task automatic m_reset();
    for (int k = 0; k < 19; k++) m_reg[k] = 8'h00;
    m_reg[0] = 8'h01; m_reg[9] = 8'h80; m_reg[15] = 8'h80; m_reg[13] = 8'h0A;
    m_addr = 0; m_stat = 0; m_dout = 0; m_sdout = 0;
  endtask

  task automatic chk(input string tag, input logic [151:0] act, input logic [151:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [151:0] img;
    for (int k = 0; k < 19; k++) img[k*8 +: 8] = m_reg[k];
    chk("R3/R4 image", reg_image, img);
    chk("R5 bus_dout", {144'h0, bus_dout}, {144'h0, m_dout});
    chk("R6 stat_dout", {144'h0, stat_dout}, {144'h0, m_sdout});
    chk("R9 irq", {151'h0, irq}, {151'h0, m_irq()});
  endtask

  task automatic step(input logic aw, input logic w, input logic r, input logic c,
                      input logic [7:0] d, input logic sr, input logic [7:0] fs);
    int s;
    addr_wr = aw; bus_wr = w; bus_rd = r; bus_chan = c; bus_din = d;
    stat_rd = sr; flag_set = fs;
    @(posedge clk);
    s = map(c, m_addr);
    if (r) m_dout = (s >= 0) ? m_reg[s] : 8'hFF;
    if (w && s >= 0) m_reg[s] = d;
    if (aw) m_addr = d;
    if (sr) m_sdout = m_stat;
    m_stat = (sr ? 8'h00 : m_stat) | fs;
    @(negedge clk);
    compare_all();
  endtask

  task automatic setaddr(input logic [7:0] a); step(1, 0, 0, 0, a, 0, 0); endtask
  task automatic wr(input logic c, input logic [7:0] d); step(0, 1, 0, c, d, 0, 0); endtask
  task automatic rd(input logic c); step(0, 0, 1, c, 0, 0, 0); endtask
  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset contents
    compare_all();
    chk("R1 addr0", {144'h0, reg_image[7:0]}, 152'h01);
    chk("R1 pcm1 entry0", {144'h0, reg_image[127:120]}, 152'h80);
    chk("R1 midi ctrl", {144'h0, reg_image[111:104]}, 152'h0A);

    // R2/R3: channel 0 write and read back
    setaddr(8'd5); wr(0, 8'h5A); rd(0);
    chk("R3 write addr5", {144'h0, bus_dout}, 152'h5A);
    // R2: latch and data in the same cycle use the old address
    step(1, 1, 0, 0, 8'd7, 0, 0);
    chk("R2 old latch used", {144'h0, reg_image[47:40]}, 152'h07);
    // R3: out-of-map write ignored, R5: reads 0xFF
    setaddr(8'd20); wr(0, 8'h33); rd(0);
    chk("R5 unmapped ch0", {144'h0, bus_dout}, 152'hFF);
    // R4: channel 1 reaches bank 1 only
    setaddr(8'd10); wr(1, 8'hC3); rd(1);
    chk("R4 ch1 bank1", {144'h0, reg_image[135:128]}, 152'hC3);
    rd(0);
    chk("R4 ch0 bank0 untouched", {144'h0, bus_dout}, 152'h00);
    setaddr(8'd2); wr(1, 8'hEE); rd(1);
    chk("R4/R5 ch1 outside window", {144'h0, bus_dout}, 152'hFF);

    // R8: enable timer 0 only (mask bits 5,6 set), open MIDI tx enable
    setaddr(8'd8); wr(0, 8'h60);
    setaddr(8'd13); wr(0, 8'h00);
    step(0, 0, 0, 0, 0, 0, 8'h87);  // overflow + fifo + rx: none enabled
    chk("R8 no irq from unenabled bits", {151'h0, irq}, 152'h0);
    step(0, 0, 0, 0, 0, 0, 8'h20);  // timer 1 masked
    chk("R8 masked timer1", {151'h0, irq}, 152'h0);
    step(0, 0, 0, 0, 0, 0, 8'h10);
    chk("R9 timer0 irq", {151'h0, irq}, 152'h1);
    // R7: collision of read and pulse
    step(0, 0, 0, 0, 0, 1, 8'h08);
    chk("R7 read omits pulse", {144'h0, stat_dout}, 152'hB7);
    chk("R9 tx irq after read", {151'h0, irq}, 152'h1);
    setaddr(8'd13); wr(0, 8'h04);
    chk("R8 tx masked", {151'h0, irq}, 152'h0);
    step(0, 0, 0, 0, 0, 1, 8'h00);
    chk("R6 read returns held bit", {144'h0, stat_dout}, 152'h08);
    idle();
    chk("R6 cleared", {151'h0, irq}, 152'h0);

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r1, r2;
      seed = seed * 32'd1664525 + 32'd1013904223; r1 = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; r2 = seed;
      step(r1[2:0] == 0, r1[4:3] == 1, r1[6:5] == 2, r1[7],
           (r1[2:0] == 0) ? (r1[20] ? 8'(r1[15:8] % 18) : r1[15:8]) : r1[15:8],
           r1[11:9] == 3, (r2[3:0] == 0) ? r2[15:8] : 8'h00);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule